// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps a small set of recent virtual-to-physical page translations, so a lookup does not have to walk the page table. A 14-bit virtual address is split into a 6-bit page offset and an 8-bit virtual page number. Within the page number, the two bits just above the offset (address bits 7:6) choose one of four sets. The upper six bits (13:8) are the tag, which is compared against all four ways of that set in parallel. A hit returns a 12-bit physical address. A miss tells the requester that the translation must be fetched from the page table.

Once a miss has been resolved elsewhere, the requester installs the translation through the fill port. A fill whose tag is already resident in the set overwrites that way. Otherwise the fill takes the lowest-numbered empty way, and when the set is full it takes the way named by that set's round-robin pointer. A flush input empties the whole cache in a single cycle, for example on a change of address space.

The block has no state machine. Its only sequential state is the per-way entry storage and the per-set replacement pointers.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every entry is invalid, so a lookup of any address reports a miss.
- R2: A lookup selects the set from virtual address bits 7:6 and compares bits 13:8 against the tags of the four ways in that set. It hits only when a valid way's tag matches. Entries held in other sets never produce a hit.
- R3: On a hit, the physical address is the stored 6-bit physical page number in bits 11:6, joined with virtual address bits 5:0 unchanged in bits 5:0. On a miss or an idle cycle the physical address is zero.
- R4: When a lookup is requested, the miss output is the inverse of the hit output. When no lookup is requested, both are low.
- R5: A fill with a tag that is not resident writes into the lowest-numbered invalid way of the indexed set.
- R6: A fill into a full set with a tag that is not resident replaces the way named by the set's 2-bit pointer, and the pointer then advances by one modulo 4. Pointers are zero after reset and after a flush.
- R7: A fill whose tag matches a valid way of its set overwrites that way's physical page number. No duplicate is created and the pointer is left unchanged.
- R8: A flush clears every valid bit and every pointer at the next clock edge.
- R9: When a flush and a fill occur in the same cycle, the flush wins and the filled translation is not resident afterwards.
- R10: A lookup is combinational from the current contents. A fill becomes visible only after the next clock edge, so a lookup in the same cycle as its fill still sees the old contents.
- R11: A fill changes only the set selected by fill page-number bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 14 | Virtual address to translate |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup miss |
| lk_pa_o | output | 12 | Translated physical address (zero unless hit) |
| fill_en_i | input | 1 | Install a translation at the next edge |
| fill_vpn_i | input | 8 | Virtual page number to install (bits 1:0 choose the set) |
| fill_ppn_i | input | 6 | Physical page number to install |
| flush_all_i | input | 1 | Invalidate every entry at the next edge |

## Verification
Two pairs of functions can land in the same cycle: a fill together with a flush, and a fill together with a lookup of the same page. The bench raises the fill and flush inputs together for a fresh page, then sweeps all 256 page numbers and expects a miss for every one. To provoke the second case it presents a lookup of the page being filled while the fill is still pending and expects the pre-fill answer; after the edge it expects a hit. Every sweep result is compared with a replacement model of the sets, ways and pointers that the bench builds from the requirements.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int DEF_VA_W  = 14;
    localparam int DEF_PA_W  = 12;
    localparam int DEF_OFF_W = 6;
    localparam int DEF_SETS  = 4;
    localparam int DEF_WAYS  = 4;
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int WAYS = 4,
    localparam int IW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0] valid_i,
    input  logic [WAYS-1:0] match_i,
    input  logic [IW-1:0]   ptr_i,
    output logic [IW-1:0]   way_o,
    output logic            repl_o
);
    always_comb begin
        way_o  = ptr_i;
        repl_o = 1'b1;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                way_o  = IW'(i);
                repl_o = 1'b0;
            end
        end
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                way_o  = IW'(i);
                repl_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tlb_set.sv
module tlb_set #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6,
    localparam int IW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [TAG_W-1:0] look_tag_i,
    output logic             look_hit_o,
    output logic [PPN_W-1:0] look_ppn_o,
    input  logic             fill_we_i,
    input  logic [TAG_W-1:0] fill_tag_i,
    input  logic [PPN_W-1:0] fill_ppn_i
);
    logic [WAYS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q [WAYS];
    logic [PPN_W-1:0] ppn_q [WAYS];
    logic [IW-1:0]    ptr_q;
    logic [WAYS-1:0]  look_vec;
    logic [WAYS-1:0]  fill_vec;
    logic [IW-1:0]    vic_way;
    logic             vic_repl;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign look_vec[g] = valid_q[g] && (tag_q[g] == look_tag_i);
        assign fill_vec[g] = valid_q[g] && (tag_q[g] == fill_tag_i);
    end

    assign look_hit_o = |look_vec;

    always_comb begin
        look_ppn_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (look_vec[w]) begin
                look_ppn_o = look_ppn_o | ppn_q[w];
            end
        end
    end

    tlb_victim #(.WAYS(WAYS)) u_victim (
        .valid_i (valid_q),
        .match_i (fill_vec),
        .ptr_i   (ptr_q),
        .way_o   (vic_way),
        .repl_o  (vic_repl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (flush_i) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (fill_we_i) begin
            valid_q[vic_way] <= 1'b1;
            if (vic_repl) begin
                ptr_q <= ptr_q + IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we_i && !flush_i) begin
            tag_q[vic_way] <= fill_tag_i;
            ppn_q[vic_way] <= fill_ppn_i;
        end
    end

    function automatic logic tag_present(input logic [TAG_W-1:0] t);
        logic f;
        f = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[w] && tag_q[w] == t) f = 1'b1;
        end
        return f;
    endfunction

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_vec)); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0 && ptr_q == '0)); // R8
    AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we_i && !flush_i) |=> tag_present($past(fill_tag_i))); // R10
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we_i && !flush_i && (&valid_q) && !(|fill_vec))
        |=> (ptr_q == IW'($past(ptr_q) + 1'b1))); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we_i && !flush_i && (|fill_vec)) |=> $stable(ptr_q)); // R7
endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W  = DEF_VA_W,
    parameter int PA_W  = DEF_PA_W,
    parameter int OFF_W = DEF_OFF_W,
    parameter int SETS  = DEF_SETS,
    parameter int WAYS  = DEF_WAYS,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int TAG_W = VPN_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid_i,
    input  logic [VA_W-1:0]  lk_va_i,
    output logic             lk_hit_o,
    output logic             lk_miss_o,
    output logic [PA_W-1:0]  lk_pa_o,
    input  logic             fill_en_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PPN_W-1:0] fill_ppn_i,
    input  logic             flush_all_i
);
    logic [SETS-1:0]  set_hit;
    logic [PPN_W-1:0] set_ppn [SETS];
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] fl_idx;
    logic [TAG_W-1:0] fl_tag;
    logic             sel_hit;

    assign lk_idx = lk_va_i[OFF_W +: IDX_W];
    assign lk_tag = lk_va_i[VA_W-1 -: TAG_W];
    assign fl_idx = fill_vpn_i[IDX_W-1:0];
    assign fl_tag = fill_vpn_i[VPN_W-1 -: TAG_W];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        tlb_set #(
            .WAYS  (WAYS),
            .TAG_W (TAG_W),
            .PPN_W (PPN_W)
        ) u_set (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush_i    (flush_all_i),
            .look_tag_i (lk_tag),
            .look_hit_o (set_hit[s]),
            .look_ppn_o (set_ppn[s]),
            .fill_we_i  (fill_en_i && (fl_idx == IDX_W'(s))),
            .fill_tag_i (fl_tag),
            .fill_ppn_i (fill_ppn_i)
        );
    end

    assign sel_hit   = set_hit[lk_idx];
    assign lk_hit_o  = lk_valid_i && sel_hit;
    assign lk_miss_o = lk_valid_i && !sel_hit;
    assign lk_pa_o   = lk_hit_o ? {set_ppn[lk_idx], lk_va_i[OFF_W-1:0]} : '0;

    AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> (lk_pa_o[OFF_W-1:0] == lk_va_i[OFF_W-1:0])); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |-> (!lk_hit_o && !lk_miss_o && lk_pa_o == '0)); // R4
    AST_AFTER_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all_i |=> !lk_hit_o); // R9
endmodule

// File: tb/sim_vpage_tlb.sv
module sim_vpage_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [13:0] lk_va = '0;
    logic        lk_hit, lk_miss;
    logic [11:0] lk_pa;
    logic        fill_en = 1'b0;
    logic [7:0]  fill_vpn = '0;
    logic [5:0]  fill_ppn = '0;
    logic        flush_all = 1'b0;

    int errors = 0;
    int checks = 0;

    logic       mv [16];
    logic [5:0] mt [16];
    logic [5:0] mp [16];
    logic [1:0] mptr [4];

    always #2 clk = ~clk;

    vpage_tlb u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_valid_i  (lk_valid),
        .lk_va_i     (lk_va),
        .lk_hit_o    (lk_hit),
        .lk_miss_o   (lk_miss),
        .lk_pa_o     (lk_pa),
        .fill_en_i   (fill_en),
        .fill_vpn_i  (fill_vpn),
        .fill_ppn_i  (fill_ppn),
        .flush_all_i (flush_all)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic m_clear();
        for (int i = 0; i < 16; i++) mv[i] = 1'b0;
        for (int i = 0; i < 4; i++) mptr[i] = 2'd0;
    endtask

    task automatic m_fill(input logic [7:0] vpn, input logic [5:0] ppn);
        int s = int'(vpn[1:0]);
        int w = -1;
        for (int i = 0; i < 4; i++)
            if (mv[s*4+i] && mt[s*4+i] == vpn[7:2]) w = i;
        if (w < 0)
            for (int i = 3; i >= 0; i--)
                if (!mv[s*4+i]) w = i;
        if (w < 0) begin
            w = int'(mptr[s]);
            mptr[s] = mptr[s] + 2'd1;
        end
        mv[s*4+w] = 1'b1;
        mt[s*4+w] = vpn[7:2];
        mp[s*4+w] = ppn;
    endtask

    function automatic logic [13:0] m_look(input logic [13:0] va);
        logic [13:0] r;
        int s = int'(va[7:6]);
        r = {1'b0, 1'b1, 12'h000};
        for (int i = 0; i < 4; i++)
            if (mv[s*4+i] && mt[s*4+i] == va[13:8]) r = {1'b1, 1'b0, mp[s*4+i], va[5:0]};
        return r;
    endfunction

    task automatic probe(input string req, input logic [13:0] va);
        lk_valid = 1'b1;
        lk_va = va;
        #1;
        check(req, {18'd0, lk_hit, lk_miss, lk_pa}, {18'd0, m_look(va)});
    endtask

    task automatic sweep(input string req);
        for (int v = 0; v < 256; v++) begin
            logic [7:0] pg = 8'(v);
            probe(req, {pg[7:2], pg[1:0], pg[5:0] ^ 6'h2A});
        end
        lk_valid = 1'b0;
    endtask

    function automatic logic [5:0] ppn_of(input logic [7:0] vpn, input int salt);
        return 6'(int'(vpn) * 7 + 3 + salt);
    endfunction

    task automatic do_fill(input logic [7:0] vpn, input logic [5:0] ppn);
        @(negedge clk);
        fill_en = 1'b1;
        fill_vpn = vpn;
        fill_ppn = ppn;
        @(negedge clk);
        fill_en = 1'b0;
        m_fill(vpn, ppn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sweep("R1");

        // fill four distinct tags into every set (R5, R11)
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] vp = {6'((k * 9 + s * 5 + 1)), 2'(s)};
                do_fill(vp, ppn_of(vp, 0));
            end
            sweep("R11");
        end
        sweep("R2,R3,R5");

        // full set 1: pointer driven replacements (R6)
        do_fill({6'h30, 2'd1}, 6'h11);
        sweep("R6");
        do_fill({6'h31, 2'd1}, 6'h12);
        sweep("R6");

        // matching tag in set 2 overwritten, pointer unchanged (R7)
        do_fill({6'd11, 2'd2}, 6'h3C);
        sweep("R7");
        do_fill({6'h32, 2'd2}, 6'h05);
        sweep("R7");

        // lookup in the same cycle as its fill (R10)
        @(negedge clk);
        fill_en = 1'b1;
        fill_vpn = {6'h3E, 2'd0};
        fill_ppn = 6'h2B;
        probe("R10", {6'h3E, 2'd0, 6'h15});
        @(negedge clk);
        fill_en = 1'b0;
        m_fill({6'h3E, 2'd0}, 6'h2B);
        probe("R10", {6'h3E, 2'd0, 6'h15});
        check("R10", 32'(lk_hit), 32'd1);
        lk_valid = 1'b0;

        // idle lookup of a resident page (R4)
        lk_va = {6'h3E, 2'd0, 6'h15};
        #1;
        check("R4", {19'd0, lk_hit, lk_miss, lk_pa}, 32'd0);

        // flush clears everything and restarts pointers (R8)
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        m_clear();
        sweep("R8");
        for (int k = 0; k < 5; k++) begin
            logic [7:0] vp = {6'(k * 3 + 2), 2'd3};
            do_fill(vp, ppn_of(vp, 5));
        end
        sweep("R8");

        // flush and fill in the same cycle: flush wins (R9)
        @(negedge clk);
        flush_all = 1'b1;
        fill_en = 1'b1;
        fill_vpn = {6'h2F, 2'd1};
        fill_ppn = 6'h19;
        @(negedge clk);
        flush_all = 1'b0;
        fill_en = 1'b0;
        m_clear();
        sweep("R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule